// File: doc/BRIEF.md
# Wrapped Line Fill Controller with Early Restart

This block services a miss on a single cache line that is built from several words. When a processor read misses, the controller asks memory for the whole line one word at a time. The first word it asks for is the one that missed. It then wraps around through the other words of the line. Memory answers in request order. The word the processor is waiting for goes straight back on the response port in the cycle it arrives, so the processor can move on while the rest of the line is still coming in.

A valid bit for each word records which words of the line have arrived. A later read of a word that is already in hits with no wait. A read of a word that has not arrived yet is held off until that word comes in, and then completes in that same cycle. A read of a different line waits until the current fill is over. The line as a whole is marked valid, along with its tag, only once its last word has been written. The tag array and the replacement policy sit outside this block.

A parameter selects a plain early-restart variant. In that variant every fetch starts at word 0, and the processor is released when its word goes past.

Top module: `lcf_fill_ctrl`

## Requirements
- R1: With CRIT_FIRST=1, the first memory request of a fill appears one cycle after the miss is presented. Its address is the missed address: the tag is in the upper TAG_W bits and the word index is in the low log2(WORDS) bits.
- R2: Each later memory request keeps the tag and adds one to the word index, wrapping modulo WORDS. A fill issues exactly WORDS requests. While mem_req_ready is low, mem_req_valid and mem_req_addr hold steady.
- R3: The missed word is returned on rsp_data in the cycle memory delivers it. With a memory latency of L cycles and no back-pressure, that is L+1 cycles after the miss is presented.
- R4: During a fill, a read of a word of the filling line that has already arrived completes in the cycle it is presented, with the stored data.
- R5: During a fill, a read of a word of the filling line that has not arrived is held with req_ready low. It completes in the cycle that word arrives, carrying that word's memory data.
- R6: A read of any other line during a fill is held until the fill completes. It is then handled as a new miss.
- R7: fill_done is high in the cycle the last word of a fill arrives. line_valid goes high and line_tag shows the filled tag from the next cycle. line_valid is low from the cycle after a new miss is accepted.
- R8: Once a line is complete, a read of any word with a matching tag completes in the cycle it is presented, with the word memory supplied.
- R9: With CRIT_FIRST=0, a fill requests word 0 first and proceeds in increasing order. The missed word is returned in the cycle it arrives, which is L+1+w cycles after the miss for word index w.
- R10: While reset is held, line_valid, mem_req_valid, fill_done and req_ready are low.
- R11: req_ready is high only while req_valid is high. rsp_valid is the request handshake. A read completes with no back-pressure on the response, and every memory response is accepted in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Processor read request is present |
| req_ready | output | 1 | Request completes this cycle |
| req_addr | input | TAG_W+log2(WORDS) | Word address {tag, word index} |
| rsp_valid | output | 1 | Read data valid (same cycle as handshake) |
| rsp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory word request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | TAG_W+log2(WORDS) | Requested word address |
| mem_rsp_valid | input | 1 | Memory returns one word (in request order) |
| mem_rsp_data | input | DATA_W | Returned word |
| fill_done | output | 1 | Last word of the fill arrives this cycle |
| line_valid | output | 1 | Held line is complete and usable |
| line_tag | output | TAG_W | Tag of the held or filling line |

## Verification
Each result has a fixed cycle at which it is due, counted from when the stimulus is presented:
- With memory latency L and no back-pressure, the missed word is due L+1 cycles after the miss.
- The word at wrap position k is due L+1+k cycles after the miss, and fill_done rises with the last of these words.
- line_valid and line_tag change one cycle after fill_done.
- A hit is due in the cycle it is presented.

The bench drives each read on a falling edge and samples one nanosecond later. It counts the cycles in which req_ready stays low and compares that count with the arithmetic value for the latency, start word and wrap position under test. A memory model inside the bench logs every accepted request address, and that log is compared with the expected wrap order once the fill is over.

// File: rtl/lcf_pkg.sv
`timescale 1ns/1ps
package lcf_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/lcf_wrap_seq.sv
`timescale 1ns/1ps
// Issues one memory request per word, starting at base and wrapping.
module lcf_wrap_seq #(
  parameter int WORDS = 4,
  parameter int TAG_W = 4,
  localparam int WI = $clog2(WORDS),
  localparam int ADDR_W = TAG_W + WI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TAG_W-1:0]  tag,
  input  logic [WI-1:0]     base,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr
);
  logic [WI-1:0] step_q;
  logic          active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      step_q   <= '0;
    end else if (active_q && ready) begin
      step_q <= step_q + 1'b1;
      if (step_q == WI'(WORDS - 1)) active_q <= 1'b0;
    end
  end

  assign valid = active_q;
  assign addr  = {tag, WI'(base + step_q)};
endmodule

// File: rtl/lcf_word_track.sv
`timescale 1ns/1ps
// Per-word arrival bits and word storage for the line being filled.
module lcf_word_track #(
  parameter int WORDS  = 4,
  parameter int DATA_W = 16,
  localparam int WI = $clog2(WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         wr_en,
  input  logic [WI-1:0]                base,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [WORDS-1:0]             have,
  output logic [WORDS-1:0][DATA_W-1:0] words,
  output logic [WI-1:0]                cur_word,
  output logic                         last
);
  logic [WI-1:0] cnt_q;

  assign cur_word = WI'(base + cnt_q);
  assign last     = (cnt_q == WI'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (wr_en)  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic hit_w;
    assign hit_w = wr_en && (cur_word == WI'(g));

    always_ff @(posedge clk) begin
      if (!rst_n)      have[g] <= 1'b0;
      else if (clear)  have[g] <= 1'b0;
      else if (hit_w)  have[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit_w) words[g] <= wr_data;
    end
  end
endmodule

// File: rtl/lcf_fill_ctrl.sv
`timescale 1ns/1ps
// Line fill controller: wrapped fetch, early restart, per-word tracking.
module lcf_fill_ctrl #(
  parameter int WORDS      = 4,
  parameter int DATA_W     = 16,
  parameter int TAG_W      = 4,
  parameter int CRIT_FIRST = 1,
  localparam int WI = $clog2(WORDS),
  localparam int ADDR_W = TAG_W + WI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              fill_done,
  output logic              line_valid,
  output logic [TAG_W-1:0]  line_tag
);
  import lcf_pkg::*;

  fill_state_e          state_q;
  logic [TAG_W-1:0]     tag_q;
  logic [WI-1:0]        base_q;
  logic                 line_vld_q;

  logic [TAG_W-1:0]     req_tag;
  logic [WI-1:0]        req_word;
  logic [WI-1:0]        first_word;
  logic                 filling, tag_hit, arriving, have_word;
  logic                 miss_start, wr_en, last_word;
  logic [WORDS-1:0]     have;
  logic [WORDS-1:0][DATA_W-1:0] words;
  logic [WI-1:0]        cur_word;

  assign req_tag  = req_addr[ADDR_W-1:WI];
  assign req_word = req_addr[WI-1:0];

  if (CRIT_FIRST != 0) begin : g_crit
    assign first_word = req_word;
  end else begin : g_seq
    assign first_word = '0;
  end

  assign filling    = (state_q == FS_FILL);
  assign tag_hit    = (req_tag == tag_q);
  assign have_word  = have[req_word];
  assign wr_en      = filling && mem_rsp_valid;
  assign arriving   = wr_en && (cur_word == req_word);
  assign miss_start = req_valid && !filling && !(line_vld_q && tag_hit);
  assign fill_done  = wr_en && last_word;

  assign req_ready  = req_valid && tag_hit &&
                      (line_vld_q || (filling && (have_word || arriving)));
  assign rsp_valid  = req_ready;
  assign rsp_data   = have_word ? words[req_word] : mem_rsp_data;

  assign line_valid = line_vld_q;
  assign line_tag   = tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FS_IDLE;
      tag_q      <= '0;
      base_q     <= '0;
      line_vld_q <= 1'b0;
    end else if (miss_start) begin
      state_q    <= FS_FILL;
      tag_q      <= req_tag;
      base_q     <= first_word;
      line_vld_q <= 1'b0;
    end else if (fill_done) begin
      state_q    <= FS_IDLE;
      line_vld_q <= 1'b1;
    end
  end

  lcf_wrap_seq #(.WORDS(WORDS), .TAG_W(TAG_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (miss_start),
    .tag   (tag_q),
    .base  (base_q),
    .ready (mem_req_ready),
    .valid (mem_req_valid),
    .addr  (mem_req_addr)
  );

  lcf_word_track #(.WORDS(WORDS), .DATA_W(DATA_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (miss_start),
    .wr_en    (wr_en),
    .base     (base_q),
    .wr_data  (mem_rsp_data),
    .have     (have),
    .words    (words),
    .cur_word (cur_word),
    .last     (last_word)
  );
endmodule

// File: rtl/lcf_fill_chk.sv
`timescale 1ns/1ps
module lcf_fill_chk #(
  parameter int WORDS      = 4,
  parameter int TAG_W      = 4,
  parameter int CRIT_FIRST = 1,
  localparam int WI = $clog2(WORDS),
  localparam int ADDR_W = TAG_W + WI
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              fill_done,
  input logic              line_valid,
  input logic [TAG_W-1:0]  line_tag
);
  if (CRIT_FIRST != 0) begin : g_first_crit
    p_first_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> mem_req_addr == $past(req_addr));
  end else begin : g_first_seq
    p_first_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> mem_req_addr == {$past(req_addr[ADDR_W-1:WI]), WI'(0)});
  end

  p_wrap_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req_valid && mem_req_ready) && mem_req_valid) |->
      (mem_req_addr[ADDR_W-1:WI] == $past(mem_req_addr[ADDR_W-1:WI]) &&
       mem_req_addr[WI-1:0] == WI'($past(mem_req_addr[WI-1:0]) + 1'b1)));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_other_line_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && req_valid && req_addr[ADDR_W-1:WI] != mem_req_addr[ADDR_W-1:WI])
      |-> !req_ready);

  p_done_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> line_valid);

  p_valid_from_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_valid) |-> $past(fill_done));

  p_miss_clears_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !line_valid);

  p_line_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && req_valid && req_addr[ADDR_W-1:WI] == line_tag) |-> req_ready);

  p_ready_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  p_rsp_is_handshake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == (req_valid && req_ready));
endmodule

bind lcf_fill_ctrl lcf_fill_chk #(
  .WORDS(WORDS), .TAG_W(TAG_W), .CRIT_FIRST(CRIT_FIRST)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .fill_done     (fill_done),
  .line_valid    (line_valid),
  .line_tag      (line_tag)
);

// File: tb/tb_lcf_fill_ctrl.sv
`timescale 1ns/1ps
// In-order memory model with fixed latency and optional request throttling.
module tb_lcf_mem #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  int            lat,
  input  logic          throttle,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [AW-1:0] q_addr [16];
  int            q_ts   [16];
  logic [AW-1:0] log_addr [16];
  int wp = 0, rp = 0, cyc = 0, log_n = 0;
  logic prev_v = 1'b0;

  function automatic logic [DW-1:0] dfun(input logic [AW-1:0] a);
    return DW'(int'(a) * 37 + 4608);
  endfunction

  initial begin
    req_ready = 1'b1;
    rsp_valid = 1'b0;
    rsp_data  = '0;
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    req_ready = throttle ? cyc[0] : 1'b1;
    if (req_valid && !prev_v) log_n = 0;
    prev_v = req_valid;
    if (req_valid && req_ready) begin
      q_addr[wp % 16] = req_addr;
      q_ts[wp % 16]   = cyc;
      wp = wp + 1;
      if (log_n < 16) begin
        log_addr[log_n] = req_addr;
        log_n = log_n + 1;
      end
    end
    if (rp != wp && (cyc - q_ts[rp % 16]) >= lat) begin
      rsp_valid = 1'b1;
      rsp_data  = dfun(q_addr[rp % 16]);
      rp = rp + 1;
    end else begin
      rsp_valid = 1'b0;
      rsp_data  = '0;
    end
  end
endmodule

module tb_lcf_fill_ctrl;
  localparam int WORDS = 4;
  localparam int DW    = 16;
  localparam int TW    = 4;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid [2];
  logic [AW-1:0] req_addr  [2];
  logic          rdy       [2];
  logic          rvld      [2];
  logic [DW-1:0] rdat      [2];
  logic          mvalid    [2];
  logic          mready    [2];
  logic [AW-1:0] maddr     [2];
  logic          mrv       [2];
  logic [DW-1:0] mrd       [2];
  logic          fdone     [2];
  logic          lvl       [2];
  logic [TW-1:0] ltag      [2];
  int            lat       [2];
  logic          thr       [2];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  lcf_fill_ctrl #(.WORDS(WORDS), .DATA_W(DW), .TAG_W(TW), .CRIT_FIRST(1)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[0]), .req_ready(rdy[0]), .req_addr(req_addr[0]),
    .rsp_valid(rvld[0]), .rsp_data(rdat[0]),
    .mem_req_valid(mvalid[0]), .mem_req_ready(mready[0]), .mem_req_addr(maddr[0]),
    .mem_rsp_valid(mrv[0]), .mem_rsp_data(mrd[0]),
    .fill_done(fdone[0]), .line_valid(lvl[0]), .line_tag(ltag[0])
  );

  lcf_fill_ctrl #(.WORDS(WORDS), .DATA_W(DW), .TAG_W(TW), .CRIT_FIRST(0)) dut_er (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid[1]), .req_ready(rdy[1]), .req_addr(req_addr[1]),
    .rsp_valid(rvld[1]), .rsp_data(rdat[1]),
    .mem_req_valid(mvalid[1]), .mem_req_ready(mready[1]), .mem_req_addr(maddr[1]),
    .mem_rsp_valid(mrv[1]), .mem_rsp_data(mrd[1]),
    .fill_done(fdone[1]), .line_valid(lvl[1]), .line_tag(ltag[1])
  );

  tb_lcf_mem #(.AW(AW), .DW(DW)) m0 (
    .clk(clk), .req_valid(mvalid[0]), .req_addr(maddr[0]), .lat(lat[0]),
    .throttle(thr[0]), .req_ready(mready[0]), .rsp_valid(mrv[0]), .rsp_data(mrd[0])
  );

  tb_lcf_mem #(.AW(AW), .DW(DW)) m1 (
    .clk(clk), .req_valid(mvalid[1]), .req_addr(maddr[1]), .lat(lat[1]),
    .throttle(thr[1]), .req_ready(mready[1]), .rsp_valid(mrv[1]), .rsp_data(mrd[1])
  );

  function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a);
    return DW'(int'(a) * 37 + 4608);
  endfunction

  function automatic logic [AW-1:0] mk(input int tag, input int w);
    return AW'(tag * WORDS + (w % WORDS));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present a read on unit u; count stall cycles; sample 1 ns after the falling edge.
  task automatic access(input int u, input logic [AW-1:0] a, output int w,
                        output logic [DW-1:0] d, output logic fd, output logic lv0);
    req_valid[u] = 1'b1;
    req_addr[u]  = a;
    w = 0;
    #1;
    lv0 = lvl[u];
    while (!rdy[u] && w < 200) begin
      @(negedge clk);
      #1;
      w++;
    end
    d  = rdat[u];
    fd = fdone[u];
    @(negedge clk);
    req_valid[u] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    logic [DW-1:0] d;
    logic fd, lv;
    int tg;
    for (int u = 0; u < 2; u++) begin
      req_valid[u] = 1'b0;
      req_addr[u]  = '0;
      lat[u] = 1;
      thr[u] = 1'b0;
    end
    rst_n = 1'b0;
    idle(3);
    #1;
    // R10: reset state
    check(lvl[0] == 0 && mvalid[0] == 0 && fdone[0] == 0 && rdy[0] == 0, "R10 reset outputs",
          int'({lvl[0], mvalid[0], fdone[0], rdy[0]}), 0);
    check(lvl[1] == 0 && mvalid[1] == 0, "R10 reset outputs early-restart",
          int'({lvl[1], mvalid[1]}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    #1;
    // R11: no ready without a request
    check(rdy[0] == 0 && rvld[0] == 0, "R11 idle no handshake", int'({rdy[0], rvld[0]}), 0);
    @(negedge clk);

    // Sweep latency and missed word on the wrapped-fetch unit
    tg = 1;
    for (int L = 1; L <= 3; L++) begin
      for (int s = 0; s < WORDS; s++) begin
        lat[0] = L;
        access(0, mk(tg, s), w, d, fd, lv);
        check(w == L + 1, "R3 critical word latency", w, L + 1);
        check(d == exp_data(mk(tg, s)), "R3 critical word data", int'(d), int'(exp_data(mk(tg, s))));
        access(0, mk(tg, s), w, d, fd, lv);
        check(w == 0, "R4 arrived word hits during fill", w, 0);
        check(d == exp_data(mk(tg, s)), "R4 arrived word data", int'(d), int'(exp_data(mk(tg, s))));
        check(lv == 0, "R7 line not valid mid fill", int'(lv), 0);
        access(0, mk(tg, s + 3), w, d, fd, lv);
        check(w == 1, "R5 stall until word arrives", w, 1);
        check(d == exp_data(mk(tg, s + 3)), "R5 late word data", int'(d), int'(exp_data(mk(tg, s + 3))));
        check(fd == 1, "R7 fill_done with last word", int'(fd), 1);
        access(0, mk(tg, s + 2), w, d, fd, lv);
        check(lv == 1, "R7 line_valid after fill", int'(lv), 1);
        check(ltag[0] == TW'(tg), "R7 line_tag after fill", int'(ltag[0]), tg);
        check(w == 0, "R8 complete line hit", w, 0);
        check(d == exp_data(mk(tg, s + 2)), "R8 complete line data", int'(d), int'(exp_data(mk(tg, s + 2))));
        check(m0.log_n == WORDS, "R2 request count", m0.log_n, WORDS);
        check(m0.log_addr[0] == mk(tg, s), "R1 first request is missed word",
              int'(m0.log_addr[0]), int'(mk(tg, s)));
        for (int k = 1; k < WORDS; k++)
          check(m0.log_addr[k] == mk(tg, s + k), "R2 wrap order",
                int'(m0.log_addr[k]), int'(mk(tg, s + k)));
        tg++;
      end
    end

    // R6: other line during a fill waits, then misses
    lat[0] = 2;
    access(0, mk(5, 1), w, d, fd, lv);
    check(w == 3, "R6 setup miss latency", w, 3);
    access(0, mk(9, 0), w, d, fd, lv);
    check(lv == 0, "R6 line invalid while filling", int'(lv), 0);
    check(w == 2 + 4, "R6 other line stall cycles", w, 6);
    check(d == exp_data(mk(9, 0)), "R6 other line data", int'(d), int'(exp_data(mk(9, 0))));
    #1;
    check(lvl[0] == 0, "R7 new miss clears line_valid", int'(lvl[0]), 0);
    idle(8);
    #1;
    check(lvl[0] == 1 && ltag[0] == TW'(9), "R7 second line valid", int'(ltag[0]), 9);
    check(m0.log_addr[0] == mk(9, 0), "R1 first request after stall",
          int'(m0.log_addr[0]), int'(mk(9, 0)));
    @(negedge clk);

    // R2 under memory back-pressure
    thr[0] = 1'b1;
    lat[0] = 1;
    access(0, mk(11, 2), w, d, fd, lv);
    check(d == exp_data(mk(11, 2)), "R3 critical data under back-pressure",
          int'(d), int'(exp_data(mk(11, 2))));
    idle(20);
    thr[0] = 1'b0;
    check(m0.log_n == WORDS, "R2 request count under back-pressure", m0.log_n, WORDS);
    for (int k = 0; k < WORDS; k++)
      check(m0.log_addr[k] == mk(11, 2 + k), "R2 wrap order under back-pressure",
            int'(m0.log_addr[k]), int'(mk(11, 2 + k)));
    for (int k = 0; k < WORDS; k++) begin
      access(0, mk(11, k), w, d, fd, lv);
      check(w == 0 && d == exp_data(mk(11, k)), "R8 every word after fill",
            int'(d), int'(exp_data(mk(11, k))));
    end

    // R9: early-restart variant starts at word 0
    lat[1] = 2;
    for (int s = 0; s < WORDS; s++) begin
      access(1, mk(3 + s, s), w, d, fd, lv);
      check(w == 2 + 1 + s, "R9 release when word passes", w, 3 + s);
      check(d == exp_data(mk(3 + s, s)), "R9 data", int'(d), int'(exp_data(mk(3 + s, s))));
      idle(10);
      check(m1.log_addr[0] == mk(3 + s, 0), "R9 fetch starts at word 0",
            int'(m1.log_addr[0]), int'(mk(3 + s, 0)));
      for (int k = 1; k < WORDS; k++)
        check(m1.log_addr[k] == mk(3 + s, k), "R9 increasing order",
              int'(m1.log_addr[k]), int'(mk(3 + s, k)));
      access(1, mk(3 + s, s), w, d, fd, lv);
      check(w == 0, "R8 hit in early-restart variant", w, 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule